// File: doc/BRIEF.md
# Difference-of-Means Trace Accumulator

This block gathers side-channel traces, each made of DEPTH signed samples that arrive in order. The caller supplies one partition bit per trace, derived outside the block from the plaintext and a key guess. Every sample at time index j is added to a running sum for bin 0 or bin 1, according to that bit. The block also counts how many traces closed in each bin, so the two bin counts always add up to the number of traces taken.

When a readout is requested, the block walks the indices upward from 0. At each index it divides both bin sums by their bin counts with a shared sequential divider. It then emits the bin-0 mean minus the bin-1 mean, one value per index. The result is a differential bias trace; its peaks show how well the partition guess matches the data. A clear pulse empties both bins so that the next key guess can be accumulated.

Top module: `dom_accum`

## Requirements
- R1: After reset, `rd_busy_o`, `diff_vld_o` and `empty_err_o` are low, and both bin counts are zero. A readout started right after reset therefore reports an empty bin.
- R2: A trace is assigned to a bin by `part_i` as sampled together with the trace's first accepted sample (0 selects bin 0, 1 selects bin 1). Changes of `part_i` later in the same trace have no effect.
- R3: A bin's trace count rises by one when a sample carrying `smp_end_i` is accepted into that bin. The two counts together equal the number of traces closed since the last clear.
- R4: For index j, the emitted value is trunc(S0[j]/N0) - trunc(S1[j]/N1). Here S is the sum of the samples at j in that bin, N is the bin's trace count, and each division truncates toward zero.
- R5: A readout emits exactly DEPTH values, each as a one-cycle `diff_vld_o` pulse, with `diff_idx_o` running 0, 1, ..., DEPTH-1 in that order. `rd_busy_o` is low from the cycle of the last value onward.
- R6: If either bin count is zero when a readout starts, `empty_err_o` goes high and stays high until the next readout start or clear. All DEPTH emitted values are then zero.
- R7: Samples presented while `rd_busy_o` is high are ignored, including their end marker.
- R8: A `clr_i` pulse zeroes all sums and both counts, drops `empty_err_o`, and aborts any readout in progress: `rd_busy_o` is low in the next cycle.
- R9: Samples beyond the DEPTH-th sample of one trace are not accumulated. Their end marker still closes the trace.
- R10: `rd_go_i` asserted while a readout is in progress is ignored; no second readout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of sums, counts and readout |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SW | Signed sample value |
| smp_end_i | input | 1 | Marks the last sample of a trace |
| part_i | input | 1 | Partition bit, sampled with the first sample of a trace |
| rd_go_i | input | 1 | Starts a readout |
| rd_busy_o | output | 1 | Readout in progress |
| diff_vld_o | output | 1 | Differential value valid |
| diff_idx_o | output | $clog2(DEPTH) | Time index of the emitted value |
| diff_o | output | SW+1 | Signed bin-0 mean minus bin-1 mean |
| empty_err_o | output | 1 | A bin was empty at readout start |

## Verification
The bench builds the block with DEPTH=8, a 12-bit sample and an 8-bit trace counter. This keeps each readout to a few hundred cycles, so many readouts fit in one run. Traces over-running the depth and mid-trace partition flips then take only a few samples to produce. A short counter also keeps the sum width small, which makes full-scale runs of -2048 and +2047 easy to reach; these show whether rounding toward zero of negative means agrees with the reference. The reference model keeps the sums and counts in plain integers and compares every emitted value and its index as it appears.

// File: rtl/dom_pkg.sv
package dom_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_LOAD0 = 2'd1,
        RD_WAIT0 = 2'd2,
        RD_WAIT1 = 2'd3
    } rd_state_e;
endpackage

// File: rtl/dom_div.sv
// Sequential signed-by-unsigned divider, truncating toward zero.
module dom_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    abort_i,
    input  logic                    start_i,
    input  logic signed [NUM_W-1:0] num_i,
    input  logic        [DEN_W-1:0] den_i,
    output logic signed [NUM_W-1:0] quo_o,
    output logic                    done_o
);
    localparam int STEP_W = $clog2(NUM_W);

    typedef struct packed {
        logic              busy;
        logic              neg;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  quo;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] shifted;
    logic [DEN_W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        shifted = {q.rem, q.quo[NUM_W-1]};
        trial   = shifted - {1'b0, den_i};
        if (abort_i) begin
            d.busy = 1'b0;
        end else if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.neg  = num_i[NUM_W-1];
            d.quo  = num_i[NUM_W-1] ? NUM_W'(-num_i) : NUM_W'(num_i);
            d.rem  = '0;
            d.step = '0;
        end else if (q.busy) begin
            if (shifted >= {1'b0, den_i}) begin
                d.rem = trial[DEN_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = shifted[DEN_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.step = q.step + 1'b1;
            if (q.step == STEP_W'(NUM_W-1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign quo_o  = q.neg ? -signed'(q.quo) : signed'(q.quo);
    assign done_o = q.done;

    // R4: a quotient is only reported at the end of a division run
    p_done_after_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(q.busy));
    // R4: the partial remainder stays below the divisor
    p_rem_below_den_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && den_i != '0) |-> (q.rem < den_i));
endmodule

// File: rtl/dom_bank.sv
// Per-index sum storage for both bins plus trace counters.
module dom_bank #(
    parameter int DEPTH = 64,
    parameter int SW    = 12,
    parameter int CNT_W = 16,
    parameter int SUM_W = 28,
    parameter int IDX_W = 6
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    acc_en_i,
    input  logic                    acc_bin_i,
    input  logic [IDX_W-1:0]        acc_idx_i,
    input  logic signed [SW-1:0]    acc_val_i,
    input  logic                    tr_end_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic signed [SUM_W-1:0] sum0_o,
    output logic signed [SUM_W-1:0] sum1_o,
    output logic [CNT_W-1:0]        cnt0_o,
    output logic [CNT_W-1:0]        cnt1_o
);
    typedef struct packed {
        logic [CNT_W-1:0] n0;
        logic [CNT_W-1:0] n1;
    } cnt_t;

    cnt_t cq, cd;
    logic signed [SUM_W-1:0] s0_q [DEPTH];
    logic signed [SUM_W-1:0] s1_q [DEPTH];
    logic signed [SUM_W-1:0] s0_d [DEPTH];
    logic signed [SUM_W-1:0] s1_d [DEPTH];
    logic signed [SUM_W-1:0] val_ext;

    assign val_ext = SUM_W'(acc_val_i);

    always_comb begin
        cd   = cq;
        s0_d = s0_q;
        s1_d = s1_q;
        if (clr_i) begin
            cd = '0;
            for (int k = 0; k < DEPTH; k++) begin
                s0_d[k] = '0;
                s1_d[k] = '0;
            end
        end else begin
            if (acc_en_i) begin
                if (acc_bin_i) s1_d[acc_idx_i] = s1_q[acc_idx_i] + val_ext;
                else           s0_d[acc_idx_i] = s0_q[acc_idx_i] + val_ext;
            end
            if (tr_end_i) begin
                if (acc_bin_i) cd.n1 = cq.n1 + 1'b1;
                else           cd.n0 = cq.n0 + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cq <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                s0_q[k] <= '0;
                s1_q[k] <= '0;
            end
        end else begin
            cq   <= cd;
            s0_q <= s0_d;
            s1_q <= s1_d;
        end
    end

    assign sum0_o = s0_q[rd_idx_i];
    assign sum1_o = s1_q[rd_idx_i];
    assign cnt0_o = cq.n0;
    assign cnt1_o = cq.n1;

    // R8: a clear leaves both counters at zero
    p_cnt_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i) |-> (cq.n0 == '0 && cq.n1 == '0));
    // R3: the total trace count grows by at most one per cycle
    p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(clr_i) |-> (({1'b0, cq.n0} + {1'b0, cq.n1}) - ({1'b0, $past(cq.n0)} + {1'b0, $past(cq.n1)})) <= (CNT_W+1)'(1));
endmodule

// File: rtl/dom_accum.sv
module dom_accum #(
    parameter int DEPTH = 64,
    parameter int SW    = 12,
    parameter int CNT_W = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic                         smp_vld_i,
    input  logic signed [SW-1:0]         smp_i,
    input  logic                         smp_end_i,
    input  logic                         part_i,
    input  logic                         rd_go_i,
    output logic                         rd_busy_o,
    output logic                         diff_vld_o,
    output logic [$clog2(DEPTH)-1:0]     diff_idx_o,
    output logic signed [SW:0]           diff_o,
    output logic                         empty_err_o
);
    import dom_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int POS_W = IDX_W + 1;
    localparam int SUM_W = SW + CNT_W;
    localparam int OUT_W = SW + 1;

    typedef struct packed {
        rd_state_e               st;
        logic [POS_W-1:0]        pos;
        logic                    mid;
        logic                    bin;
        logic [IDX_W-1:0]        ridx;
        logic                    err;
        logic signed [SUM_W-1:0] m0;
        logic                    out_vld;
        logic [IDX_W-1:0]        out_idx;
        logic signed [OUT_W-1:0] out_val;
    } top_t;

    top_t q, d;

    logic                    busy, take, bin_now, acc_en, tr_end;
    logic signed [SUM_W-1:0] sum0, sum1, div_num, div_quo, dsum;
    logic [CNT_W-1:0]        cnt0, cnt1, div_den;
    logic                    div_start, div_done;

    assign busy    = (q.st != RD_IDLE);
    assign take    = smp_vld_i && !busy && !clr_i;
    assign bin_now = q.mid ? q.bin : part_i;
    assign acc_en  = take && (q.pos < POS_W'(DEPTH));
    assign tr_end  = take && smp_end_i;

    assign div_num   = (q.st == RD_WAIT0) ? sum1 : sum0;
    assign div_den   = (q.st == RD_WAIT1) ? cnt1 : cnt0;
    assign div_start = ((q.st == RD_LOAD0) && !q.err) || ((q.st == RD_WAIT0) && div_done);
    assign dsum      = q.m0 - div_quo;

    dom_bank #(
        .DEPTH(DEPTH), .SW(SW), .CNT_W(CNT_W), .SUM_W(SUM_W), .IDX_W(IDX_W)
    ) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr_i),
        .acc_en_i  (acc_en),
        .acc_bin_i (bin_now),
        .acc_idx_i (q.pos[IDX_W-1:0]),
        .acc_val_i (smp_i),
        .tr_end_i  (tr_end),
        .rd_idx_i  (q.ridx),
        .sum0_o    (sum0),
        .sum1_o    (sum1),
        .cnt0_o    (cnt0),
        .cnt1_o    (cnt1)
    );

    dom_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) div_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .abort_i (clr_i),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .quo_o   (div_quo),
        .done_o  (div_done)
    );

    always_comb begin
        d         = q;
        d.out_vld = 1'b0;
        // sample intake
        if (take) begin
            if (smp_end_i) begin
                d.pos = '0;
                d.mid = 1'b0;
            end else begin
                d.mid = 1'b1;
                d.bin = bin_now;
                if (q.pos < POS_W'(DEPTH)) d.pos = q.pos + 1'b1;
            end
        end
        // readout sequencer
        unique case (q.st)
            RD_IDLE: begin
                if (rd_go_i) begin
                    d.st   = RD_LOAD0;
                    d.ridx = '0;
                    d.err  = (cnt0 == '0) || (cnt1 == '0);
                end
            end
            RD_LOAD0: begin
                if (q.err) begin
                    d.out_vld = 1'b1;
                    d.out_idx = q.ridx;
                    d.out_val = '0;
                    if (q.ridx == IDX_W'(DEPTH-1)) d.st = RD_IDLE;
                    else                          d.ridx = q.ridx + 1'b1;
                end else begin
                    d.st = RD_WAIT0;
                end
            end
            RD_WAIT0: begin
                if (div_done) begin
                    d.m0 = div_quo;
                    d.st = RD_WAIT1;
                end
            end
            RD_WAIT1: begin
                if (div_done) begin
                    d.out_vld = 1'b1;
                    d.out_idx = q.ridx;
                    d.out_val = dsum[OUT_W-1:0];
                    if (q.ridx == IDX_W'(DEPTH-1)) begin
                        d.st = RD_IDLE;
                    end else begin
                        d.ridx = q.ridx + 1'b1;
                        d.st   = RD_LOAD0;
                    end
                end
            end
            default: d.st = RD_IDLE;
        endcase
        if (clr_i) begin
            d.st  = RD_IDLE;
            d.err = 1'b0;
            d.pos = '0;
            d.mid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rd_busy_o   = busy;
    assign diff_vld_o  = q.out_vld;
    assign diff_idx_o  = q.out_idx;
    assign diff_o      = q.out_val;
    assign empty_err_o = q.err;

    // R6: an empty bin forces zero outputs
    p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (diff_vld_o && empty_err_o) |-> (diff_o == '0));
    // R5: values only come out of an active readout
    p_vld_from_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        diff_vld_o |-> $past(q.st != RD_IDLE));
    // R5: the readout index never steps backward
    p_ridx_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && $past(busy) && !$past(clr_i)) |-> (q.ridx >= $past(q.ridx)));
    // R8: clear aborts the readout at once
    p_clear_aborts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i) |-> (!rd_busy_o && !diff_vld_o && !empty_err_o));
endmodule

// File: tb/dom_accum_tb_top.sv
module dom_accum_tb_top;
    localparam int D  = 8;
    localparam int SW = 12;
    localparam int CW = 8;
    localparam int IW = $clog2(D);

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic clr_i = 1'b0, smp_vld_i = 1'b0, smp_end_i = 1'b0, part_i = 1'b0, rd_go_i = 1'b0;
    logic signed [SW-1:0] smp_i = '0;
    logic rd_busy_o, diff_vld_o, empty_err_o;
    logic [IW-1:0] diff_idx_o;
    logic signed [SW:0] diff_o;

    always #5 clk_i = ~clk_i;

    dom_accum #(.DEPTH(D), .SW(SW), .CNT_W(CW)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .smp_vld_i(smp_vld_i),
        .smp_i(smp_i), .smp_end_i(smp_end_i), .part_i(part_i), .rd_go_i(rd_go_i),
        .rd_busy_o(rd_busy_o), .diff_vld_o(diff_vld_o), .diff_idx_o(diff_idx_o),
        .diff_o(diff_o), .empty_err_o(empty_err_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int s0 [D];
    int s1 [D];
    int n0 = 0, n1 = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < D; k++) begin s0[k] = 0; s1[k] = 0; end
        n0 = 0; n1 = 0;
    endtask

    function automatic int pick(input int mode);
        if (mode == 1) return -2048;
        if (mode == 2) return 2047;
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    // Sends one trace of len samples; when flip is set part_i toggles after the first sample.
    task automatic send_trace(input bit b, input int len, input bit flip, input int mode, input bit upd);
        for (int k = 0; k < len; k++) begin
            int v;
            v = pick(mode);
            @(negedge clk_i);
            smp_vld_i = 1'b1;
            smp_i     = SW'(v);
            smp_end_i = (k == len - 1);
            part_i    = (flip && k > 0) ? ~b : b;
            if (upd && k < D) begin
                if (b) s1[k] += v; else s0[k] += v;
            end
        end
        if (upd) begin if (b) n1++; else n0++; end
        @(negedge clk_i);
        smp_vld_i = 1'b0; smp_end_i = 1'b0;
    endtask

    function automatic int exp_val(input int j);
        if (n0 == 0 || n1 == 0) return 0;
        return (s0[j] / n0) - (s1[j] / n1);
    endfunction

    task automatic pulse_go();
        @(negedge clk_i);
        rd_go_i = 1'b1;
        @(negedge clk_i);
        rd_go_i = 1'b0;
    endtask

    // Full readout with per-value comparison against the model.
    task automatic readout(input string req);
        int got;
        bit experr;
        got = 0;
        experr = (n0 == 0 || n1 == 0);
        @(negedge clk_i);
        rd_go_i = 1'b1;
        for (int t = 0; t < 5000 && got < D; t++) begin
            @(negedge clk_i);
            rd_go_i = 1'b0;
            if (diff_vld_o) begin
                chk(int'(diff_idx_o) == got, {req, " R5 index"}, int'(diff_idx_o), got);
                chk(int'(diff_o) == exp_val(got), {req, " R4 value"}, int'(diff_o), exp_val(got));
                chk(empty_err_o == experr, {req, " R6 flag"}, int'(empty_err_o), int'(experr));
                got++;
            end
        end
        chk(got == D, {req, " R5 count"}, got, D);
        chk(rd_busy_o == 1'b0, {req, " R5 busy low at end"}, int'(rd_busy_o), 0);
        for (int t = 0; t < 200; t++) begin
            @(negedge clk_i);
            if (diff_vld_o) begin
                chk(1'b0, {req, " R10 extra value"}, 1, 0);
                break;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1: idle reset state
        chk(rd_busy_o == 0, "R1 busy", int'(rd_busy_o), 0);
        chk(diff_vld_o == 0, "R1 valid", int'(diff_vld_o), 0);
        chk(empty_err_o == 0, "R1 err", int'(empty_err_o), 0);
        // R1/R6: empty readout after reset
        readout("R1 R6 after reset");
        chk(empty_err_o == 1, "R6 flag held", int'(empty_err_o), 1);

        // R2, R3, R4: mixed traces, one with a flipping partition bit
        for (int t = 0; t < 5; t++) send_trace(1'b0, D, 1'b0, 0, 1'b1);
        for (int t = 0; t < 3; t++) send_trace(1'b1, D, 1'b0, 0, 1'b1);
        send_trace(1'b0, D, 1'b1, 0, 1'b1);
        send_trace(1'b1, D, 1'b1, 0, 1'b1);
        readout("R2 R3 R4 mixed");
        chk(empty_err_o == 0, "R6 flag clears on good readout", int'(empty_err_o), 0);

        // R9: over-long trace, extra samples dropped
        send_trace(1'b1, D + 3, 1'b0, 0, 1'b1);
        readout("R9 long trace");

        // R7 and R10: samples and a second start during an active readout
        fork
            readout("R7 R10 busy");
            begin
                wait (rd_busy_o == 1'b1);
                send_trace(1'b0, D, 1'b0, 2, 1'b0);
                @(negedge clk_i); rd_go_i = 1'b1;
                @(negedge clk_i); rd_go_i = 1'b0;
            end
        join
        readout("R7 unchanged");

        // R8: clear during readout aborts
        pulse_go();
        repeat (20) @(negedge clk_i);
        chk(rd_busy_o == 1, "R8 busy before clear", int'(rd_busy_o), 1);
        clr_i = 1'b1;
        @(negedge clk_i);
        clr_i = 1'b0;
        chk(rd_busy_o == 0, "R8 aborted", int'(rd_busy_o), 0);
        model_clear();

        // R6, R8: only bin 1 filled after clear -> error and zeros
        send_trace(1'b1, D, 1'b0, 0, 1'b1);
        readout("R6 R8 one bin");

        // R4: full-scale negative and positive rounding toward zero
        send_trace(1'b0, D, 1'b0, 1, 1'b1);
        send_trace(1'b0, D, 1'b0, 2, 1'b1);
        send_trace(1'b0, D, 1'b0, 1, 1'b1);
        send_trace(1'b1, D, 1'b0, 2, 1'b1);
        readout("R4 extremes");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule